// File: doc/BRIEF.md
# Per-CPU One-Shot Alarm Timer

This block keeps a free-running wall-clock count of nanoseconds and gives each of up to four processors a private one-shot alarm. On every clock the count advances by a fixed step. Software reaches the block through a processor-register access port. A processor reads the wall time, programs an absolute 64-bit deadline for its own alarm, or cancels that alarm by writing zero. When the count reaches an armed deadline, the block latches an expiry bit for that processor in a shared status register. It keeps that processor's timer interrupt raised until software clears the bit by writing a one to it.

The access port has no back-pressure: every request with `acc_valid` high is taken in the cycle it is presented. A read returns its data one cycle later with `rd_valid`. A read that names destination index 31 is dropped and raises no `rd_valid`. The register numbers are: 249 for status (read, write-one-to-clear), 250 for wall time (read only) and 251 for the requesting processor's alarm deadline (read and write). `acc_cpu` selects which processor's alarm register 251 reaches.

Top module: `alarm_timer_hub`

## Requirements
- R1: After reset the wall count is zero. On every clock it rises by STEP_NS (default 4).
- R2: A read of register 250 returns, one cycle later on `rd_data` with `rd_valid` high, the count as it stood in the cycle the read was presented. Writes to register 250 are ignored.
- R3: A nonzero write to register 251 arms that processor's alarm at the written absolute deadline. The alarm fires once, in the first cycle in which the count is greater than or equal to the deadline, and then disarms until it is written again. The status bit and the interrupt rise one cycle after firing.
- R4: A deadline that is already at or below the count when it is written fires in the first cycle after the write.
- R5: A write of zero to register 251 cancels that processor's pending alarm, and no interrupt follows.
- R6: A read of register 251 returns the last nonzero deadline written for the selected processor, or zero if none has been written since reset.
- R7: Expiry for processor n sets bit n+4 of the status register (register 249). `timer_irq[n]` stays high while that bit is set. Writing a one to bit n+4 of register 249 clears it; a zero leaves it. Bits 0 to 3 read as zero.
- R8: The alarms are independent: one processor's deadline raises only its own interrupt.
- R9: A read with `acc_dest` equal to 31 is discarded: `rd_valid` stays low.
- R10: Any other register number reads as zero with `rd_valid` high, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access request, accepted at once |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_cpu | input | 2 | Requesting processor index |
| acc_regno | input | 8 | Processor register number |
| acc_dest | input | 5 | Destination index of a read (31 discards it) |
| acc_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 64 | Read data |
| timer_irq | output | 4 | Per-processor timer interrupt |

## Verification
The assertions assume that reset is held for at least one clock edge and that requests change only between edges. They also assume that `acc_cpu` names a processor that exists. The one-shot and cancel properties take a write to register 251 as the only thing that may re-arm an alarm. The bench drives every request at the falling edge, uses only processor indices 0 to 3, and keeps deadlines small enough that the count never wraps. This keeps all stimulus within those assumptions.

// File: rtl/alarm_hub_pkg.sv
package alarm_hub_pkg;
  localparam int REG_STATUS = 249;
  localparam int REG_WALL   = 250;
  localparam int REG_ALARM  = 251;
  localparam int DEST_NULL  = 31;
  localparam int IRQ_BASE   = 4;
  localparam int STAT_W     = 8;

  typedef enum logic [1:0] {SEL_NONE, SEL_STATUS, SEL_WALL, SEL_ALARM} regsel_e;
endpackage

// File: rtl/wall_counter.sv
module wall_counter #(
  parameter int TW      = 64,
  parameter int STEP_NS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] now
);
  localparam logic [TW-1:0] STEP = TW'(STEP_NS);

  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= now + STEP;
  end
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] now,
  input  logic          wr_en,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] deadline,
  output logic          fire
);
  logic armed;

  always_comb fire = armed && (now >= deadline);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      deadline <= '0;
    end else if (wr_en) begin
      if (wdata != '0) begin
        deadline <= wdata;
        armed    <= 1'b1;
      end else begin
        armed    <= 1'b0;
      end
    end else if (fire) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/alarm_status.sv
module alarm_status
  import alarm_hub_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCPU-1:0]   fire,
  input  logic              clr_en,
  input  logic [STAT_W-1:0] clr_mask,
  output logic [STAT_W-1:0] status,
  output logic [NCPU-1:0]   irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else begin
      for (int i = 0; i < NCPU; i++) begin
        if (fire[i])
          status[IRQ_BASE+i] <= 1'b1;
        else if (clr_en && clr_mask[IRQ_BASE+i])
          status[IRQ_BASE+i] <= 1'b0;
      end
    end
  end

  generate
    for (genvar u = 0; u < STAT_W; u++) begin : g_unused
      if (u < IRQ_BASE || u >= IRQ_BASE + NCPU) begin : g_zero
        initial status[u] = 1'b0;
      end
    end
  endgenerate

  assign irq = status[IRQ_BASE +: NCPU];
endmodule

// File: rtl/alarm_timer_hub.sv
module alarm_timer_hub
  import alarm_hub_pkg::*;
#(
  parameter int NCPU    = 4,
  parameter int TW      = 64,
  parameter int RW      = 8,
  parameter int STEP_NS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [1:0]      acc_cpu,
  input  logic [RW-1:0]   acc_regno,
  input  logic [4:0]      acc_dest,
  input  logic [TW-1:0]   acc_wdata,
  output logic            rd_valid,
  output logic [TW-1:0]   rd_data,
  output logic [NCPU-1:0] timer_irq
);
  logic [TW-1:0]     now;
  logic [NCPU-1:0]   fire;
  logic [NCPU-1:0]   wr_alarm;
  logic [TW-1:0]     deadline [NCPU];
  logic [STAT_W-1:0] status;
  regsel_e           sel;
  logic              clr_en;

  always_comb begin
    unique case (int'(acc_regno))
      REG_STATUS: sel = SEL_STATUS;
      REG_WALL:   sel = SEL_WALL;
      REG_ALARM:  sel = SEL_ALARM;
      default:    sel = SEL_NONE;
    endcase
  end

  assign clr_en = acc_valid && acc_write && (sel == SEL_STATUS);

  wall_counter #(.TW(TW), .STEP_NS(STEP_NS)) u_wall (
    .clk(clk), .rst_n(rst_n), .now(now)
  );

  generate
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      assign wr_alarm[c] = acc_valid && acc_write && (sel == SEL_ALARM) &&
                           (int'(acc_cpu) == c);
      alarm_unit #(.TW(TW)) u_alarm (
        .clk(clk), .rst_n(rst_n), .now(now),
        .wr_en(wr_alarm[c]), .wdata(acc_wdata),
        .deadline(deadline[c]), .fire(fire[c])
      );
    end
  endgenerate

  alarm_status #(.NCPU(NCPU)) u_status (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .clr_en(clr_en), .clr_mask(acc_wdata[STAT_W-1:0]),
    .status(status), .irq(timer_irq)
  );

  logic [TW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_STATUS: rd_mux = TW'(status);
      SEL_WALL:   rd_mux = now;
      SEL_ALARM:  if (int'(acc_cpu) < NCPU) rd_mux = deadline[acc_cpu];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write && (int'(acc_dest) != DEST_NULL);
      if (acc_valid && !acc_write && (int'(acc_dest) != DEST_NULL))
        rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/alarm_timer_hub_chk.sv
module alarm_timer_hub_chk
  import alarm_hub_pkg::*;
#(
  parameter int NCPU    = 4,
  parameter int TW      = 64,
  parameter int RW      = 8,
  parameter int STEP_NS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic            acc_write,
  input logic [1:0]      acc_cpu,
  input logic [RW-1:0]   acc_regno,
  input logic [4:0]      acc_dest,
  input logic [TW-1:0]   acc_wdata,
  input logic            rd_valid,
  input logic [TW-1:0]   rd_data,
  input logic [NCPU-1:0] timer_irq,
  input logic [TW-1:0]   now,
  input logic [NCPU-1:0] fire
);
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> now == $past(now) + TW'(STEP_NS));

  p_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_dest == 5'd31) |=> !rd_valid);

  p_undecoded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_dest != 5'd31 &&
     int'(acc_regno) != REG_STATUS && int'(acc_regno) != REG_WALL &&
     int'(acc_regno) != REG_ALARM) |=> (rd_valid && rd_data == '0));

  generate
    for (genvar c = 0; c < NCPU; c++) begin : g_chk
      p_fire_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire[c] && !(acc_valid && acc_write && int'(acc_regno) == REG_ALARM &&
                      int'(acc_cpu) == c)) |=> !fire[c]);

      p_fire_posts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire[c] |=> timer_irq[c]);

      p_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && int'(acc_regno) == REG_ALARM &&
         int'(acc_cpu) == c && acc_wdata == '0) |=> !fire[c]);

      p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_irq[c] && !(acc_valid && acc_write && int'(acc_regno) == REG_STATUS &&
                           acc_wdata[IRQ_BASE+c])) |=> timer_irq[c]);
    end
  endgenerate
endmodule

bind alarm_timer_hub alarm_timer_hub_chk #(
  .NCPU(NCPU), .TW(TW), .RW(RW), .STEP_NS(STEP_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_cpu(acc_cpu), .acc_regno(acc_regno), .acc_dest(acc_dest),
  .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
  .timer_irq(timer_irq), .now(now), .fire(fire)
);

// File: tb/test_alarm_timer_hub.sv
module test_alarm_timer_hub;
  localparam int STEP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0]  acc_cpu = '0;
  logic [7:0]  acc_regno = '0;
  logic [4:0]  acc_dest = 5'd1;
  logic [63:0] acc_wdata = '0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic [3:0]  timer_irq;

  int tests = 0, fails = 0;
  int nedge = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) nedge <= nedge + 1;

  alarm_timer_hub #(.STEP_NS(STEP)) i_alarm_timer_hub (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input int cpu, input int rno, input logic [63:0] d);
    acc_valid = 1; acc_write = 1; acc_cpu = 2'(cpu); acc_regno = 8'(rno); acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic do_read(input int cpu, input int rno, input int dest,
                         output logic [63:0] d, output logic v, output int n);
    n = nedge;
    acc_valid = 1; acc_write = 0; acc_cpu = 2'(cpu); acc_regno = 8'(rno); acc_dest = 5'(dest);
    @(negedge clk);
    acc_valid = 0; acc_dest = 5'd1;
    d = rd_data; v = rd_valid;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // arm cpu at absolute deadline d and check the interrupt edge exactly
  task automatic arm_expect(input string req, input int cpu, input longint d);
    int n, ready, e, early;
    n = nedge;
    ready = int'((d + STEP - 1) / STEP);
    e = ((ready > n + 1) ? ready : n + 1) + 1;
    do_write(cpu, 251, 64'(d));
    early = 0;
    while (nedge < e) begin
      if (timer_irq[cpu]) early = 1;
      @(negedge clk);
    end
    check({req, " no early irq"}, 64'(early), 64'd0);
    check({req, " irq at deadline"}, 64'(timer_irq[cpu]), 64'd1);
  endtask

  localparam logic [33:0] VEC [6] = '{
    {2'd0, 32'd10}, {2'd1, 32'd3}, {2'd2, 32'd1},
    {2'd3, 32'd0},  {2'd0, 32'd25}, {2'd2, 32'd7}
  };

  initial begin
    #(4 * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] d, d2; logic v; int n, n2;
    longint dl;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and counting
    check("R1 irq after reset", 64'(timer_irq), 64'd0);
    check("R1 rd_valid after reset", 64'(rd_valid), 64'd0);
    do_read(0, 250, 2, d, v, n);
    check("R2 wall read", d, 64'(n) * STEP);
    check("R2 wall valid", 64'(v), 64'd1);
    idle(5);
    do_read(1, 250, 3, d2, v, n2);
    check("R1 count step", d2 - d, 64'(n2 - n) * STEP);
    do_write(0, 250, 64'h1234);
    do_read(0, 250, 3, d, v, n);
    check("R2 wall write ignored", d, 64'(n) * STEP);

    // vector table: R3 per-cpu alarm at offsets
    foreach (VEC[i]) begin
      int cpu; int off;
      cpu = int'(VEC[i][33:32]); off = int'(VEC[i][31:0]);
      arm_expect("R3", cpu, longint'(nedge + off) * STEP);
      do_read(cpu, 249, 4, d, v, n);
      check("R7 status bit", d, 64'd1 << (cpu + 4));
      do_write(cpu, 249, 64'd1 << (cpu + 4));
      check("R7 w1c clears irq", 64'(timer_irq), 64'd0);
    end

    // R3 one-shot: no refire
    idle(20);
    check("R3 one-shot no refire", 64'(timer_irq), 64'd0);

    // R4 past deadline
    arm_expect("R4", 1, longint'(STEP));
    do_write(1, 249, 64'h00);
    check("R7 zero write keeps bit", 64'(timer_irq), 64'b0010);
    do_write(1, 249, 64'h20);

    // R5 cancel, R6 readback
    dl = longint'(nedge + 6) * STEP;
    do_write(2, 251, 64'(dl));
    do_write(2, 251, 64'd0);
    idle(20);
    check("R5 cancel no irq", 64'(timer_irq), 64'd0);
    do_read(2, 251, 5, d, v, n);
    check("R6 readback last nonzero", d, 64'(dl));

    // R10 undecoded
    do_write(2, 7, 64'hdead);
    do_read(2, 7, 6, d, v, n);
    check("R10 undecoded reads zero", d, 64'd0);
    check("R10 undecoded valid", 64'(v), 64'd1);
    do_read(2, 251, 5, d, v, n);
    check("R10 write ignored", d, 64'(dl));

    // R9 discard
    do_read(0, 250, 31, d, v, n);
    check("R9 dest31 no valid", 64'(v), 64'd0);

    // R8 independence
    do_write(3, 251, 64'(longint'(nedge + 40) * STEP));
    do_write(1, 251, 64'(longint'(nedge + 4) * STEP));
    idle(10);
    check("R8 only cpu1", 64'(timer_irq), 64'b0010);
    idle(40);
    check("R8 cpu1 and cpu3", 64'(timer_irq), 64'b1010);
    do_read(0, 249, 4, d, v, n);
    check("R8 status bits", d, 64'hA0);
    do_write(0, 249, 64'hAF);
    check("R7 clear both", 64'(timer_irq), 64'd0);
    do_read(0, 249, 4, d, v, n);
    check("R7 low bits zero", d, 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule